// File: doc/BRIEF.md
# DVB-ASI Sync-Stuffing 8b/10b Encoder

This block is the transmit front end of an asynchronous serial transport link. It takes one byte per clock from a parallel bus, together with a flag that marks the byte as a control character and a sync-insert request. When the request is high, the byte is discarded and the comma control character K28.5 is sent in its place. This lets a slower upstream FIFO, whose empty flag drives the request, be padded up to the link's fixed symbol rate of one code group per 27 MHz clock.

Every symbol, inserted or not, then passes through an 8b/10b encoder that carries running disparity from one symbol to the next. The result is a 10-bit code group with a valid strobe. The parallel bus is wider than a byte, and its upper bits have no function here. A control request that names a byte with no control encoding is replaced by a comma and flagged.

Top module: `asi_sync_encoder`

## Requirements
- R1: While `insync` is high, the code group produced for that clock is K28.5 at the current running disparity, whatever `data_in` and `kin` carry. `code_err` stays low for that group.
- R2: K28.5 is emitted as 0011111010 when running disparity is negative and as 1100000101 when it is positive. Here `code_out[9]` holds bit a and `code_out[0]` holds bit j. Each K28.5 flips the running disparity.
- R3: A data byte (`kin` low) maps to D.x.y, with x = `data_in[4:0]` and y = `data_in[7:5]`. Every code group has 4, 5 or 6 ones. A group with 6 ones is only sent at negative disparity and leaves it positive. A group with 4 ones is only sent at positive disparity and leaves it negative. A stream of data groups never has more than five equal bits in a row and never contains 0011111 or 1100000. Each 10-bit group decodes to exactly one symbol, whatever the disparity.
- R4: With `kin` high, exactly twelve bytes are valid control characters: K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Their code groups never coincide with a data group. K28.y starts with 001111 at negative disparity and with 110000 at positive disparity.
- R5: With `kin` high and `insync` low, a byte that is not a valid control character yields K28.5, and `code_err` is high for that one group only.
- R6: A synchronous reset clears `code_valid`, `code_err` and `code_out` and sets running disparity to negative. `code_valid` is high on every clock after reset is released.
- R7: Each code group appears on the outputs one rising clock edge after its inputs are sampled.
- R8: `data_in` bits above bit 7 have no effect on the output.
- R9: The alternate D.x.7 sub-block is used where needed. The bench checks these values: D0.0 at negative disparity is 1001110100, D17.7 at negative disparity is 1000110111, D11.7 at positive disparity is 1101001000, and D21.5 is 1010101010 at either disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one code group per cycle |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | BUS_W (10) | Parallel bus; bits 7:0 carry the byte, the rest are ignored |
| kin | input | 1 | Byte is a control character |
| insync | input | 1 | Replace this symbol with K28.5 (FIFO-empty stuffing) |
| code_out | output | 10 | Encoded group, bit a in bit 9 down to bit j in bit 0 |
| code_valid | output | 1 | Code group is valid |
| code_err | output | 1 | Invalid control byte was replaced by a comma |

## Verification
Every result is due exactly one rising edge after its inputs are presented. This covers the code group, the error flag, the running disparity it implies, and the comma that replaces a stuffed or invalid symbol. The bench drives inputs on a falling edge and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. One check reads the output just after new inputs are driven, before the edge, to confirm it still shows the previous group. Running disparity is never read from inside the design. The bench rebuilds it from the ones count of each output group, and it steers disparity to a wanted state by stuffing a comma, because a comma always flips it.

// File: rtl/asi_enc_pkg.sv
package asi_enc_pkg;

    localparam int SYM_W  = 8;
    localparam int CODE_W = 10;

    localparam logic [SYM_W-1:0]  COMMA_BYTE = 8'hBC;
    localparam logic [CODE_W-1:0] COMMA_NEG  = 10'b0011111010;
    localparam logic [CODE_W-1:0] COMMA_POS  = 10'b1100000101;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              err;
        rd_e               rd;
    } enc_state_t;

    localparam enc_state_t ENC_RESET = '{code: '0, valid: 1'b0, err: 1'b0, rd: RD_NEG};

    function automatic logic [2:0] ones6(input logic [5:0] v);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < 6; i++) n = n + {2'b00, v[i]};
        return n;
    endfunction

    function automatic logic [2:0] ones4(input logic [3:0] v);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < 4; i++) n = n + {2'b00, v[i]};
        return n;
    endfunction

endpackage

// File: rtl/asi_sym_select.sv
module asi_sym_select
    import asi_enc_pkg::*;
#(
    parameter int BUS_W = 10
) (
    input  logic [BUS_W-1:0] bus_in,
    input  logic             kin,
    input  logic             insync,
    output logic [SYM_W-1:0] sym,
    output logic             sym_is_k,
    output logic             bad_k
);

    logic [SYM_W-1:0] raw;
    logic [4:0]       x_fld;
    logic [2:0]       y_fld;
    logic             k_legal;

    assign raw   = bus_in[SYM_W-1:0];
    assign x_fld = raw[4:0];
    assign y_fld = raw[7:5];

    generate
        if (BUS_W > SYM_W) begin : g_spare
            logic unused_spare_bits;
            assign unused_spare_bits = ^bus_in[BUS_W-1:SYM_W];
        end
    endgenerate

    always_comb begin
        k_legal = (x_fld == 5'd28) ||
                  ((y_fld == 3'd7) &&
                   ((x_fld == 5'd23) || (x_fld == 5'd27) ||
                    (x_fld == 5'd29) || (x_fld == 5'd30)));
        sym      = raw;
        sym_is_k = kin;
        bad_k    = 1'b0;
        if (insync) begin
            sym      = COMMA_BYTE;
            sym_is_k = 1'b1;
        end else if (kin && !k_legal) begin
            sym      = COMMA_BYTE;
            sym_is_k = 1'b1;
            bad_k    = 1'b1;
        end
    end

endmodule

// File: rtl/asi_enc_6b.sv
module asi_enc_6b
    import asi_enc_pkg::*;
(
    input  logic [4:0] x_in,
    input  logic       is_k,
    input  rd_e        rd_in,
    output logic [5:0] code6,
    output rd_e        rd_mid
);

    logic [5:0] base;
    logic [2:0] n_base;
    logic [2:0] n_code;

    always_comb begin
        case (x_in)
            5'd0:  base = 6'b100111;
            5'd1:  base = 6'b011101;
            5'd2:  base = 6'b101101;
            5'd3:  base = 6'b110001;
            5'd4:  base = 6'b110101;
            5'd5:  base = 6'b101001;
            5'd6:  base = 6'b011001;
            5'd7:  base = 6'b111000;
            5'd8:  base = 6'b111001;
            5'd9:  base = 6'b100101;
            5'd10: base = 6'b010101;
            5'd11: base = 6'b110100;
            5'd12: base = 6'b001101;
            5'd13: base = 6'b101100;
            5'd14: base = 6'b011100;
            5'd15: base = 6'b010111;
            5'd16: base = 6'b011011;
            5'd17: base = 6'b100011;
            5'd18: base = 6'b010011;
            5'd19: base = 6'b110010;
            5'd20: base = 6'b001011;
            5'd21: base = 6'b101010;
            5'd22: base = 6'b011010;
            5'd23: base = 6'b111010;
            5'd24: base = 6'b110011;
            5'd25: base = 6'b100110;
            5'd26: base = 6'b010110;
            5'd27: base = 6'b110110;
            5'd28: base = 6'b001110;
            5'd29: base = 6'b101110;
            5'd30: base = 6'b011110;
            default: base = 6'b101011;
        endcase
        if (is_k && (x_in == 5'd28)) base = 6'b001111;

        n_base = ones6(base);
        // balanced words are sent as-is, except x=7 which alternates
        if ((n_base == 3'd3) && (x_in != 5'd7)) code6 = base;
        else                                     code6 = (rd_in == RD_POS) ? ~base : base;

        n_code = ones6(code6);
        if (n_code == 3'd3)     rd_mid = rd_in;
        else if (n_code > 3'd3) rd_mid = RD_POS;
        else                    rd_mid = RD_NEG;
    end

endmodule

// File: rtl/asi_enc_4b.sv
module asi_enc_4b
    import asi_enc_pkg::*;
(
    input  logic [2:0] y_in,
    input  logic [4:0] x_in,
    input  logic       is_k,
    input  rd_e        rd_in,
    output logic [3:0] code4,
    output rd_e        rd_out
);

    logic [3:0] base;
    logic [2:0] n_code;
    logic       use_alt;

    always_comb begin
        use_alt = 1'b0;
        base    = 4'b0000;
        if (is_k) begin
            case (y_in)
                3'd0: base = 4'b1011;
                3'd1: base = 4'b0110;
                3'd2: base = 4'b1010;
                3'd3: base = 4'b1100;
                3'd4: base = 4'b1101;
                3'd5: base = 4'b0101;
                3'd6: base = 4'b1001;
                default: base = 4'b0111;
            endcase
            code4 = (rd_in == RD_POS) ? ~base : base;
        end else if (y_in == 3'd7) begin
            // alternate form avoids a run of five after these 6b words
            use_alt = ((rd_in == RD_NEG) &&
                       ((x_in == 5'd17) || (x_in == 5'd18) || (x_in == 5'd20))) ||
                      ((rd_in == RD_POS) &&
                       ((x_in == 5'd11) || (x_in == 5'd13) || (x_in == 5'd14)));
            base  = use_alt ? 4'b0111 : 4'b1110;
            code4 = (rd_in == RD_POS) ? ~base : base;
        end else begin
            case (y_in)
                3'd0: base = 4'b1011;
                3'd1: base = 4'b1001;
                3'd2: base = 4'b0101;
                3'd3: base = 4'b1100;
                3'd4: base = 4'b1101;
                3'd5: base = 4'b1010;
                default: base = 4'b0110;
            endcase
            if ((ones4(base) == 3'd2) && (y_in != 3'd3)) code4 = base;
            else code4 = (rd_in == RD_POS) ? ~base : base;
        end

        n_code = ones4(code4);
        if (n_code == 3'd2)     rd_out = rd_in;
        else if (n_code > 3'd2) rd_out = RD_POS;
        else                    rd_out = RD_NEG;
    end

endmodule

// File: rtl/asi_sync_encoder.sv
module asi_sync_encoder
    import asi_enc_pkg::*;
#(
    parameter int BUS_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  data_in,
    input  logic              kin,
    input  logic              insync,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              code_err
);

    enc_state_t       state_d;
    enc_state_t       state_q;

    logic [SYM_W-1:0] sym;
    logic             sym_is_k;
    logic             bad_k;
    logic [5:0]       code6;
    logic [3:0]       code4;
    rd_e              rd_mid;
    rd_e              rd_next;
    logic             rd_pos;

    asi_sym_select #(.BUS_W(BUS_W)) u_sel (
        .bus_in   (data_in),
        .kin      (kin),
        .insync   (insync),
        .sym      (sym),
        .sym_is_k (sym_is_k),
        .bad_k    (bad_k)
    );

    asi_enc_6b u_6b (
        .x_in   (sym[4:0]),
        .is_k   (sym_is_k),
        .rd_in  (state_q.rd),
        .code6  (code6),
        .rd_mid (rd_mid)
    );

    asi_enc_4b u_4b (
        .y_in   (sym[7:5]),
        .x_in   (sym[4:0]),
        .is_k   (sym_is_k),
        .rd_in  (rd_mid),
        .code4  (code4),
        .rd_out (rd_next)
    );

    always_comb begin
        state_d       = state_q;
        state_d.code  = {code6, code4};
        state_d.valid = 1'b1;
        state_d.err   = bad_k;
        state_d.rd    = rd_next;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ENC_RESET;
        else     state_q <= state_d;
    end

    assign code_out   = state_q.code;
    assign code_valid = state_q.valid;
    assign code_err   = state_q.err;
    assign rd_pos     = (state_q.rd == RD_POS);

endmodule

// File: rtl/asi_sync_encoder_chk.sv
module asi_sync_encoder_chk
    import asi_enc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              insync,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid,
    input logic              code_err,
    input logic              rd_pos
);

    // R1
    sync_subst_chk: assert property (@(posedge clk) disable iff (rst)
        insync |=> ((code_out == COMMA_NEG) || (code_out == COMMA_POS)) && !code_err);

    // R5
    err_comma_chk: assert property (@(posedge clk) disable iff (rst)
        code_err |-> ((code_out == COMMA_NEG) || (code_out == COMMA_POS)));

    // R3
    disp_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (($countones(code_out) >= 4) && ($countones(code_out) <= 6)));

    // R3
    rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && ($countones(code_out) != 5)) |-> (rd_pos == ($countones(code_out) == 6)));

    // R2
    comma_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && (code_out == COMMA_NEG)) |-> rd_pos);

    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> code_valid);

endmodule

bind asi_sync_encoder asi_sync_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .insync     (insync),
    .code_out   (code_out),
    .code_valid (code_valid),
    .code_err   (code_err),
    .rd_pos     (rd_pos)
);

// File: tb/tb_asi_sync_encoder.sv
`timescale 1ns/1ps
module tb_asi_sync_encoder;

    localparam logic [9:0] K_NEG = 10'b0011111010;
    localparam logic [9:0] K_POS = 10'b1100000101;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] data_in;
    logic       kin;
    logic       insync;
    logic [9:0] code_out;
    logic       code_valid;
    logic       code_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic bench_rd;
    logic [9:0] prev_code;
    bit   prev_data;
    logic [9:0] seen [1024];
    logic [9:0] c, c2;
    logic e, e2;
    int   kcount;

    always #2.5 clk = ~clk;

    asi_sync_encoder #(.BUS_W(10)) dut (
        .clk(clk), .rst(rst), .data_in(data_in), .kin(kin), .insync(insync),
        .code_out(code_out), .code_valid(code_valid), .code_err(code_err)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int max_run(input logic [19:0] v);
        int best = 1, cur = 1;
        for (int i = 1; i < 20; i++) begin
            if (v[i] == v[i-1]) cur++; else cur = 1;
            if (cur > best) best = cur;
        end
        return best;
    endfunction

    function automatic bit has_comma(input logic [19:0] v);
        for (int i = 0; i <= 13; i++)
            if (v[i +: 7] == 7'b0011111 || v[i +: 7] == 7'b1100000) return 1'b1;
        return 1'b0;
    endfunction

    // one symbol: drive now (at a falling edge), read at the next falling edge
    task automatic step(input logic [9:0] bus, input logic k, input logic s,
                        output logic [9:0] code, output logic err);
        int  n;
        bit  cur_data;
        data_in = bus; kin = k; insync = s;
        @(negedge clk);
        code = code_out; err = code_err;
        n = $countones(code);
        check(code_valid === 1'b1, "R6 valid", {15'd0, code_valid}, 16'd1);
        if (s) begin
            check(code === (bench_rd ? K_POS : K_NEG), "R1 stuffed comma", {6'd0, code},
                  {6'd0, (bench_rd ? K_POS : K_NEG)});
            check(err === 1'b0, "R1 no error", {15'd0, err}, 16'd0);
        end
        check(n >= 4 && n <= 6, "R3 ones count", n[15:0], 16'd5);
        if (n == 6) begin
            check(bench_rd == 1'b0, "R3 +2 group at neg rd", {15'd0, bench_rd}, 16'd0);
            bench_rd = 1'b1;
        end else if (n == 4) begin
            check(bench_rd == 1'b1, "R3 -2 group at pos rd", {15'd0, bench_rd}, 16'd1);
            bench_rd = 1'b0;
        end
        cur_data = !s && !k;
        if (cur_data && prev_data) begin
            check(max_run({prev_code, code}) <= 5, "R3 run length",
                  max_run({prev_code, code}), 16'd5);
            check(!has_comma({prev_code, code}), "R3 no comma in data", {6'd0, code}, 16'd0);
        end
        prev_code = code;
        prev_data = cur_data;
    endtask

    task automatic set_rd(input logic want);
        logic [9:0] cc; logic ee;
        if (bench_rd != want) step(10'h000, 1'b0, 1'b1, cc, ee);
    endtask

    task automatic record(input logic [9:0] code, input logic k, input logic [7:0] b);
        if (seen[code][9] == 1'b0) seen[code] = {1'b1, k, b};
        else check(seen[code] == {1'b1, k, b}, "R3 R4 unique decode", {6'd0, seen[code]},
                   {6'd0, 1'b1, k, b});
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) seen[i] = '0;
        rst = 1'b1; data_in = '0; kin = 1'b0; insync = 1'b0;
        bench_rd = 1'b0; prev_code = '0; prev_data = 0;
        repeat (3) @(negedge clk);
        // R6 reset state
        check(code_valid === 1'b0, "R6 reset valid", {15'd0, code_valid}, 16'd0);
        check(code_err === 1'b0, "R6 reset err", {15'd0, code_err}, 16'd0);
        check(code_out === 10'd0, "R6 reset code", {6'd0, code_out}, 16'd0);
        rst = 1'b0;

        // R1 R2: stuffing ignores data and kin, commas alternate
        step(10'h3FF, 1'b1, 1'b1, c, e);
        check(c === K_NEG, "R2 comma at neg rd", {6'd0, c}, {6'd0, K_NEG});
        step(10'h000, 1'b0, 1'b1, c, e);
        check(c === K_POS, "R2 comma at pos rd", {6'd0, c}, {6'd0, K_POS});

        // R7: output unchanged before the edge, new group after it
        data_in = 10'h0B5; kin = 1'b0; insync = 1'b0;
        #1;
        check(code_out === K_POS, "R7 no early change", {6'd0, code_out}, {6'd0, K_POS});
        step(10'h0B5, 1'b0, 1'b0, c, e);
        check(c === 10'b1010101010, "R7 R9 D21.5 after one edge", {6'd0, c}, 16'h02AA);

        // R9 spot values
        set_rd(1'b0);
        step(10'h000, 1'b0, 1'b0, c, e);
        check(c === 10'b1001110100, "R9 D0.0 neg", {6'd0, c}, 16'h0274);
        set_rd(1'b0);
        step(10'h0F1, 1'b0, 1'b0, c, e);
        check(c === 10'b1000110111, "R9 D17.7 neg alternate", {6'd0, c}, 16'h0237);
        set_rd(1'b1);
        step(10'h0EB, 1'b0, 1'b0, c, e);
        check(c === 10'b1101001000, "R9 D11.7 pos alternate", {6'd0, c}, 16'h0348);
        set_rd(1'b1);
        step(10'h0B5, 1'b0, 1'b0, c, e);
        check(c === 10'b1010101010, "R9 D21.5 pos", {6'd0, c}, 16'h02AA);

        // R3: every data byte at both disparities
        for (int b = 0; b < 256; b++) begin
            step({2'b00, b[7:0]}, 1'b0, 1'b0, c, e);
            check(e === 1'b0, "R3 no error on data", {15'd0, e}, 16'd0);
            record(c, 1'b0, b[7:0]);
            if ($countones(c) == 5) step(10'h000, 1'b0, 1'b1, c2, e2);
            step({2'b00, b[7:0]}, 1'b0, 1'b0, c, e);
            record(c, 1'b0, b[7:0]);
        end

        // R4 R5: every byte as a control request at both disparities
        kcount = 0;
        for (int b = 0; b < 256; b++) begin
            for (int r = 0; r < 2; r++) begin
                bit legal;
                logic rd_before;
                legal = (b[4:0] == 5'd28) ||
                        (b[7:5] == 3'd7 && (b[4:0] == 5'd23 || b[4:0] == 5'd27 ||
                                            b[4:0] == 5'd29 || b[4:0] == 5'd30));
                set_rd(r[0]);
                rd_before = bench_rd;
                step({2'b00, b[7:0]}, 1'b1, 1'b0, c, e);
                if (legal) begin
                    if (r == 0) kcount++;
                    check(e === 1'b0, "R4 legal control no error", {15'd0, e}, 16'd0);
                    record(c, 1'b1, b[7:0]);
                    if (b[4:0] == 5'd28)
                        check(c[9:4] === (rd_before ? 6'b110000 : 6'b001111), "R4 K28 prefix",
                              {10'd0, c[9:4]}, {10'd0, (rd_before ? 6'b110000 : 6'b001111)});
                end else begin
                    check(e === 1'b1, "R5 error flag", {15'd0, e}, 16'd1);
                    check(c === (rd_before ? K_POS : K_NEG), "R5 comma replaces", {6'd0, c},
                          {6'd0, (rd_before ? K_POS : K_NEG)});
                end
            end
        end
        check(kcount == 12, "R4 twelve legal controls", kcount[15:0], 16'd12);

        // R5: error lasts one group
        step(10'h001, 1'b1, 1'b0, c, e);
        check(e === 1'b1, "R5 error raised", {15'd0, e}, 16'd1);
        step(10'h0B5, 1'b0, 1'b0, c, e);
        check(e === 1'b0, "R5 error cleared", {15'd0, e}, 16'd0);

        // R8: spare bus bits have no effect
        for (int b = 0; b < 256; b += 37) begin
            set_rd(1'b0);
            step({2'b00, b[7:0]}, 1'b0, 1'b0, c, e);
            set_rd(1'b0);
            step({2'b11, b[7:0]}, 1'b0, 1'b0, c2, e2);
            check(c === c2, "R8 spare bits ignored", {6'd0, c2}, {6'd0, c});
        end

        // R6: mid-run reset returns disparity to negative
        set_rd(1'b1);
        rst = 1'b1;
        @(negedge clk);
        check(code_valid === 1'b0, "R6 valid cleared", {15'd0, code_valid}, 16'd0);
        rst = 1'b0;
        bench_rd = 1'b0; prev_data = 0;
        step(10'h000, 1'b0, 1'b1, c, e);
        check(c === K_NEG, "R6 neg rd after reset", {6'd0, c}, {6'd0, K_NEG});

        done = 1;
        report();
        $finish;
    end

endmodule